// File: doc/BRIEF.md
# Warning-Lamp Status Feedback Monitor

This block forms the status feedback bit for one warning-lamp channel. It takes the lamp command together with two digitised sense flags from the analog front end. One flag says the driver output voltage is above its detection threshold. The other says the driver output current is above its threshold. A command-dependent truth table maps these three bits to a single feedback level. A healthy channel reads 1 while the lamp is off and 0 while it is on. Shorts to ground, shorts to the battery rail, an open load and an internal driver failure each drive the opposite level.

All three inputs pass through a reset-cleared synchroniser. After the command changes, a two-state controller holds the feedback at its previous value and drops the ready flag. It waits for a settling time, given as a count of prescaled ticks, and only then publishes a fresh result. The states are `ST_SETTLE` (waiting, feedback frozen) and `ST_TRACK` (feedback follows the sense flags). The transitions are:

- `T_EXPIRE` (settle to track, when the timer is done and the command has not changed).
- `T_CMD_EDGE` (track to settle, when the command changes).
- `T_RESTART` (settle to settle, when the command changes during settling and the timer starts over).
- `T_HOLD` (track to track, when the command is steady).

Top module: `lampfb_monitor`

## Requirements
- R1: While reset is asserted, and on the first clock edge after it is released, fb_level is 1 and fb_ready is 0.
- R2: With the command low (lamp off) and the channel settled, fb_level equals sense_v_hi: 1 when the output voltage is above threshold, 0 when the output is pulled to ground.
- R3: With the command high (lamp on) and the channel settled, fb_level is 0 only when sense_v_hi is 0 and sense_i_hi is 1 (a healthy lit lamp). Every other flag combination gives 1.
- R4: When lamp_cmd changes on a settled channel, fb_ready falls on rising edge SYNC_STAGES+1, counting the first edge that samples the new command as edge 1. From then until settling ends, fb_level keeps the value it had before the change.
- R5: fb_ready rises, and fb_level takes the value R2/R3 give for the present inputs, on edge SETTLE_TICKS*TICK_DIV+SYNC_STAGES+2, counted the same way, and not earlier. After reset is released, fb_ready rises on edge SETTLE_TICKS*TICK_DIV+1.
- R6: A further command change while settling restarts the full settling time from that change. fb_level keeps its pre-settle value throughout.
- R7: On a settled channel with a steady command, a change of the sense flags reaches fb_level on rising edge SYNC_STAGES+1 and not before.
- R8: Sense flag changes during settling neither shorten nor lengthen the settling time, and they do not alter fb_level before settling ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lamp_cmd | input | 1 | Lamp command, 1 = lamp on |
| sense_v_hi | input | 1 | Output voltage above detection threshold |
| sense_i_hi | input | 1 | Output current above detection threshold |
| fb_level | output | 1 | Status feedback level |
| fb_ready | output | 1 | 1 when fb_level reflects the present command |

## Verification
The bench uses SYNC_STAGES=2, TICK_DIV=4 and SETTLE_TICKS=8.

- A sense-flag change on a settled channel is due on the third rising edge. The bench checks that the old level is still present after the second edge and that the new one appears after the third.
- A command change drops fb_ready after the third edge. Ready and the new feedback are due on edge 36. The bench samples fb_ready low and the frozen level after edge 35, then samples the new values after edge 36.
- After reset release, readiness is due on edge 33, and the bench samples after edges 32 and 33.

All sampling happens on falling edges, and inputs are driven on falling edges, so every check lands in a known cycle.

// File: rtl/lampfb_pkg.sv
package lampfb_pkg;

    typedef enum logic [0:0] {
        ST_SETTLE = 1'b0,
        ST_TRACK  = 1'b1
    } fb_state_e;

    typedef struct packed {
        logic cmd;
        logic v_hi;
        logic i_hi;
    } lamp_sense_t;

    localparam int SENSE_W = $bits(lamp_sense_t);

    // Healthy off lamp: voltage high. Healthy on lamp: voltage low, current high.
    function automatic logic fb_truth(input logic cmd, input logic v_hi, input logic i_hi);
        logic res;
        if (cmd) res = v_hi | ~i_hi;
        else     res = v_hi;
        return res;
    endfunction

endpackage

// File: rtl/lampfb_sync.sv
module lampfb_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= '0;
                    else        chain_q[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/lampfb_timer.sv
module lampfb_timer #(
    parameter int TICK_DIV     = 500,
    parameter int SETTLE_TICKS = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic done
);

    localparam int DIV_W  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int TICK_W = $clog2(SETTLE_TICKS + 1);
    localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(TICK_DIV - 1);
    localparam logic [TICK_W-1:0] TICK_GOAL = TICK_W'(SETTLE_TICKS);

    logic [DIV_W-1:0]  div_q;
    logic [TICK_W-1:0] tick_q;
    logic              tick_pulse;

    assign tick_pulse = (div_q == DIV_LAST);
    assign done       = (tick_q == TICK_GOAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            tick_q <= '0;
        end else if (restart) begin
            div_q  <= '0;
            tick_q <= '0;
        end else if (!done) begin
            if (tick_pulse) begin
                div_q  <= '0;
                tick_q <= tick_q + 1'b1;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lampfb_eval.sv
module lampfb_eval
    import lampfb_pkg::*;
(
    input  lamp_sense_t sense,
    output logic        fb
);

    assign fb = fb_truth(sense.cmd, sense.v_hi, sense.i_hi);

endmodule

// File: rtl/lampfb_monitor.sv
module lampfb_monitor
    import lampfb_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int TICK_DIV     = 500,
    parameter int SETTLE_TICKS = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lamp_cmd,
    input  logic sense_v_hi,
    input  logic sense_i_hi,
    output logic fb_level,
    output logic fb_ready
);

    lamp_sense_t        raw_in;
    lamp_sense_t        synced;
    logic [SENSE_W-1:0] synced_bits;
    logic               cmd_s;
    logic               v_s;
    logic               i_s;
    logic               cmd_ref_q;
    logic               cmd_chg;
    logic               settle_done;
    logic               eval_fb;
    logic               fb_q;
    fb_state_e          state_q;
    fb_state_e          state_d;

    assign raw_in.cmd  = lamp_cmd;
    assign raw_in.v_hi = sense_v_hi;
    assign raw_in.i_hi = sense_i_hi;

    lampfb_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (SENSE_W)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_in),
        .d_out (synced_bits)
    );

    assign synced = lamp_sense_t'(synced_bits);
    assign cmd_s  = synced.cmd;
    assign v_s    = synced.v_hi;
    assign i_s    = synced.i_hi;

    assign cmd_chg = cmd_s ^ cmd_ref_q;

    lampfb_timer #(
        .TICK_DIV     (TICK_DIV),
        .SETTLE_TICKS (SETTLE_TICKS)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cmd_chg),
        .done    (settle_done)
    );

    lampfb_eval eval_i (
        .sense (synced),
        .fb    (eval_fb)
    );

    // Next-state: T_EXPIRE, T_CMD_EDGE, T_RESTART, T_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SETTLE: if (!cmd_chg && settle_done) state_d = ST_TRACK;
            ST_TRACK:  if (cmd_chg)                 state_d = ST_SETTLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_SETTLE;
            cmd_ref_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            cmd_ref_q <= cmd_s;
        end
    end

    // Output register: refresh only when heading into or staying in tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  fb_q <= 1'b1;
        else if (state_d == ST_TRACK) fb_q <= eval_fb;
    end

    assign fb_level = fb_q;
    assign fb_ready = (state_q == ST_TRACK);

endmodule

// File: rtl/lampfb_monitor_chk.sv
module lampfb_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic fb_level,
    input logic fb_ready,
    input logic cmd_s,
    input logic v_s,
    input logic i_s,
    input logic cmd_chg,
    input logic settle_done
);

    p_reset_vals_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (fb_level && !fb_ready));

    p_off_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_ready && !cmd_chg && !cmd_s) |=> (fb_level == $past(v_s)));

    p_on_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_ready && !cmd_chg && cmd_s) |=> (fb_level == !(!$past(v_s) && $past(i_s))));

    p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_chg |=> !fb_ready);

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_ready |=> (fb_ready || $stable(fb_level)));

    p_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_done && !cmd_chg && !fb_ready) |=> fb_ready);

    p_not_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fb_ready) |-> $past(settle_done));

    p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_chg |=> !settle_done);

    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_done && !cmd_chg) |=> settle_done);

endmodule

bind lampfb_monitor lampfb_monitor_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .fb_level    (fb_level),
    .fb_ready    (fb_ready),
    .cmd_s       (cmd_s),
    .v_s         (v_s),
    .i_s         (i_s),
    .cmd_chg     (cmd_chg),
    .settle_done (settle_done)
);

// File: tb/lampfb_monitor_tb_top.sv
module lampfb_monitor_tb_top;

    localparam int SYNC   = 2;
    localparam int DIV    = 4;
    localparam int TICKS  = 8;
    localparam int SETL   = TICKS * DIV;
    localparam int CMD_LAT = SETL + SYNC + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lamp_cmd = 1'b0;
    logic sense_v_hi = 1'b1;
    logic sense_i_hi = 1'b0;
    logic fb_level;
    logic fb_ready;

    int n_checks = 0;
    int n_fail = 0;
    logic cur_cmd = 1'b0;
    logic cur_fb = 1'b1;

    always #10 clk = ~clk;

    lampfb_monitor #(
        .SYNC_STAGES  (SYNC),
        .TICK_DIV     (DIV),
        .SETTLE_TICKS (TICKS)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .lamp_cmd   (lamp_cmd),
        .sense_v_hi (sense_v_hi),
        .sense_i_hi (sense_i_hi),
        .fb_level   (fb_level),
        .fb_ready   (fb_ready)
    );

    function automatic logic exp_fb(input logic c, input logic v, input logic i);
        if (c) return !(!v && i);
        return v;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    // Sense flags change with steady command on a settled channel
    task automatic set_flags(input logic v, input logic i);
        logic e;
        sense_v_hi = v;
        sense_i_hi = i;
        step(SYNC);
        chk("R7 fb before latency", fb_level, cur_fb);
        step(1);
        e = exp_fb(cur_cmd, v, i);
        chk(cur_cmd ? "R3 on truth" : "R2 off truth", fb_level, e);
        cur_fb = e;
    endtask

    // Command change with new flags on a settled channel
    task automatic set_cmd(input logic c, input logic v, input logic i);
        logic e;
        lamp_cmd = c;
        sense_v_hi = v;
        sense_i_hi = i;
        step(SYNC);
        chk("R4 ready still high", fb_ready, 1'b1);
        step(1);
        chk("R4 ready dropped", fb_ready, 1'b0);
        step(CMD_LAT - SYNC - 2);
        chk("R5 not ready early", fb_ready, 1'b0);
        chk("R4 fb held", fb_level, cur_fb);
        step(1);
        e = exp_fb(c, v, i);
        chk("R5 ready on time", fb_ready, 1'b1);
        chk(c ? "R3 on after settle" : "R2 off after settle", fb_level, e);
        cur_cmd = c;
        cur_fb = e;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end

    initial begin
        int seed_junk;
        seed_junk = $urandom(32'd4711);
        step(4);
        chk("R1 fb reset", fb_level, 1'b1);
        chk("R1 ready reset", fb_ready, 1'b0);
        rst_n = 1'b1;
        step(1);
        chk("R1 fb first edge", fb_level, 1'b1);
        step(SETL - 1);
        chk("R5 reset not early", fb_ready, 1'b0);
        step(1);
        chk("R5 reset ready", fb_ready, 1'b1);
        chk("R2 healthy off", fb_level, 1'b1);

        // Off-lamp: output shorted to ground, then recovered
        set_flags(1'b0, 1'b1);
        set_flags(1'b1, 1'b1);

        // On-lamp, healthy, then each fault pattern
        set_cmd(1'b1, 1'b0, 1'b1);
        set_flags(1'b1, 1'b1);
        set_flags(1'b0, 1'b0);
        set_flags(1'b1, 1'b0);
        set_flags(1'b0, 1'b1);

        // R6: restart during settling
        begin
            logic held;
            held = cur_fb;
            lamp_cmd = 1'b0;
            sense_v_hi = 1'b0;
            sense_i_hi = 1'b0;
            step(20);
            chk("R6 fb held mid settle", fb_level, held);
            lamp_cmd = 1'b1;
            sense_v_hi = 1'b1;
            step(CMD_LAT - 1);
            chk("R6 ready not before restart window", fb_ready, 1'b0);
            chk("R6 fb held after restart", fb_level, held);
            step(1);
            chk("R6 ready after restart", fb_ready, 1'b1);
            chk("R6 fb new value", fb_level, exp_fb(1'b1, 1'b1, 1'b0));
            cur_cmd = 1'b1;
            cur_fb = exp_fb(1'b1, 1'b1, 1'b0);
        end

        // R8: flag churn while settling
        begin
            logic held;
            held = cur_fb;
            lamp_cmd = 1'b0;
            step(10);
            sense_v_hi = 1'b0;
            step(7);
            chk("R8 fb held under churn", fb_level, held);
            sense_i_hi = 1'b1;
            step(5);
            sense_v_hi = 1'b1;
            step(CMD_LAT - 23);
            chk("R8 ready not early", fb_ready, 1'b0);
            chk("R8 fb held late", fb_level, held);
            step(1);
            chk("R8 ready on time", fb_ready, 1'b1);
            chk("R8 fb after churn", fb_level, exp_fb(1'b0, 1'b1, 1'b1));
            cur_cmd = 1'b0;
            cur_fb = exp_fb(1'b0, 1'b1, 1'b1);
        end

        // Random mix
        for (int k = 0; k < 60; k++) begin
            logic rv;
            logic ri;
            rv = 1'($urandom);
            ri = 1'($urandom);
            if (($urandom % 4) == 0) set_cmd(!cur_cmd, rv, ri);
            else                     set_flags(rv, ri);
        end

        report();
    end

endmodule